// File: doc/BRIEF.md
# Eight-Channel Audio Mixing Matrix

This block forms eight output audio channels from one frame of eight signed input samples. Every output is a weighted sum of all eight inputs, and the weights come from a bank of 64 fixed-point gain coefficients (one row of eight per output). After reset the bank is an identity matrix, so each output carries its own input unchanged until software programs other gains.

Coefficients are loaded through a byte-wide register-write port of the kind a decoded serial control interface delivers. A subaddress strobe selects one output mixer, and the data bytes that follow fill that mixer's eight gains. Writes land in a shadow copy of the bank. The shadow copy moves into the working bank only when a new input frame is accepted, so a frame is never computed with a mixture of old and new gains. One multiplier is shared across the 64 products, so the block is busy for 64 cycles per frame and holds off new frames while busy.

Top module: `chanmix_matrix`

## Requirements
- R1: For every output o, the result is sum over i of x[i]*g[o][i], formed at full precision, then arithmetically shifted right by 23 (rounding toward minus infinity) and clipped to the signed 24-bit range. Input and output channel k occupy bits [24k+23:24k] of their frame buses.
- R2: A gain is a 28-bit two's-complement value with 23 fraction bits (0x0080_0000 is unity, 0xF80_0000 is minus one), carried in a 32-bit word whose top four bits are discarded on write.
- R3: Subaddress 0x40+n (n = 1..8) selects output mixer n, carried on output channel n-1. The following 32 bytes form eight words for input channels 1..8 in that order, and each word is sent most significant byte first.
- R4: After reset, the gain from input k to output k is unity and every other gain is zero, so every output equals its own input.
- R5: Only complete words change a gain. A trailing partial word is dropped when the next subaddress arrives, and bytes after the 32nd of a write change nothing.
- R6: After a subaddress outside 0x41..0x48, data bytes change no gain.
- R7: Gains move from the shadow copy to the working bank on the edge that accepts a frame. A word that completes on that same edge, or at any time while a frame is in progress, first affects the next accepted frame.
- R8: After reset in_rdy is 1, out_vld is 0 and out_frame is 0. A frame is accepted when in_vld and in_rdy are both 1. in_rdy then stays 0 until out_vld rises, exactly 64 cycles after the accepting edge. out_vld is a one-cycle pulse, and out_frame does not change between pulses.
- R9: When the subaddress strobe and the byte strobe are both high in one cycle, the subaddress is taken and the byte is discarded. The byte count for the new subaddress starts at zero.
- R10: Sums above 8388607 or below -8388608 after the shift come out as exactly those limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sub_stb | input | 1 | Subaddress strobe |
| cfg_sub | input | 8 | Subaddress value |
| cfg_byte_stb | input | 1 | Data byte strobe |
| cfg_byte | input | 8 | Data byte |
| in_vld | input | 1 | Input frame valid |
| in_rdy | output | 1 | Block idle, frame can be taken |
| in_frame | input | 192 | Eight signed 24-bit input samples |
| out_vld | output | 1 | One-cycle pulse: new mixed frame |
| out_frame | output | 192 | Eight signed 24-bit mixed samples |

## Verification
The two activities that collide are coefficient loading and frame acceptance: a gain word can complete on the very edge that copies the shadow bank into the working bank. The bench sends the final byte of a word in the same cycle it raises in_vld. It expects that frame to use the old gain and the following frame to use the new one. It also streams a full mixer write while a frame is being computed and checks that the current result is unaffected. Every output is compared with a 64-bit arithmetic model of the sum, shift and clip.

// File: rtl/chanmix_pkg.sv
`timescale 1ns/1ps
package chanmix_pkg;

   // Loader state: bytes are either accepted into the shadow bank or dropped
   typedef enum logic [0:0] {
      WS_SKIP = 1'b0,
      WS_TAKE = 1'b1
   } wr_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/chanmix_sat.sv
`timescale 1ns/1ps
module chanmix_sat #(
   parameter int unsigned IW       = 32,
   parameter int unsigned OW       = 24,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [IW-1:0] din,
   output logic [OW-1:0] dout
);

   if (IW <= OW) begin : g_bad_width
      $error("chanmix_sat: input must be wider than output");
   end

   if (SATURATE) begin : g_clip
      logic fits;
      // value fits when every bit above the output sign copies the sign
      assign fits = (din[IW-1:OW-1] == {(IW-OW+1){din[IW-1]}});
      assign dout = fits ? din[OW-1:0] : {din[IW-1], {(OW-1){~din[IW-1]}}};
   end else begin : g_wrap
      logic unused_hi;
      assign unused_hi = ^din[IW-1:OW];
      assign dout      = din[OW-1:0];
   end

endmodule

// File: rtl/chanmix_coef_bank.sv
`timescale 1ns/1ps
module chanmix_coef_bank
   import chanmix_pkg::*;
#(
   parameter int unsigned NCH      = 8,
   parameter int unsigned CW       = 28,
   parameter int unsigned WORDW    = 32,
   parameter int unsigned FRAC     = 23,
   parameter logic [7:0]  SUB_BASE = 8'h41
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sub_stb,
   input  logic [7:0]              sub_addr,
   input  logic                    byte_stb,
   input  logic [7:0]              byte_dat,
   input  logic                    commit,
   input  logic [$clog2(NCH)-1:0]  rd_row,
   input  logic [$clog2(NCH)-1:0]  rd_col,
   output logic [CW-1:0]           rd_coef
);

   localparam int unsigned RW     = $clog2(NCH);
   localparam int unsigned BPW    = WORDW / 8;
   localparam int unsigned BSW    = $clog2(BPW);
   localparam int unsigned NBYTES = NCH * BPW;
   localparam int unsigned BCW    = $clog2(NBYTES);
   localparam int unsigned HW     = CW - 8;
   localparam int unsigned NC     = NCH * NCH;
   localparam int unsigned BW     = NC * CW;

   function automatic logic [BW-1:0] ident_bank();
      logic [BW-1:0] v;
      v = '0;
      for (int r = 0; r < int'(NCH); r++) begin
         v[(r * NCH + r) * CW +: CW] = CW'(1) << FRAC;
      end
      return v;
   endfunction

   localparam logic [BW-1:0] IDENT = ident_bank();

   wr_state_e        ws_q;
   logic [RW-1:0]    row_q;
   logic [BCW-1:0]   cnt_q;
   logic [HW-1:0]    hold_q;
   logic [8:0]       sub_off;
   logic             sub_hit;
   logic             byte_take;
   logic             word_last;
   logic             word_wen;
   logic [RW-1:0]    wcol;
   logic [2*RW-1:0]  wk;
   logic [CW-1:0]    word_val;
   logic [BW-1:0]    shd_q;
   logic [BW-1:0]    act_q;

   // ---------------- subaddress decode ----------------
   assign sub_off = {1'b0, sub_addr} - {1'b0, SUB_BASE};
   assign sub_hit = (sub_off < 9'(NCH));

   // ---------------- byte assembly ----------------
   assign byte_take = byte_stb && !sub_stb && (ws_q == WS_TAKE);
   assign word_last = &cnt_q[BSW-1:0];
   assign wcol      = cnt_q[BCW-1:BSW];
   assign wk        = {row_q, wcol};
   assign word_val  = {hold_q, byte_dat};
   assign word_wen  = byte_take && word_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_q   <= WS_SKIP;
         row_q  <= '0;
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (sub_stb) begin
         ws_q   <= sub_hit ? WS_TAKE : WS_SKIP;
         row_q  <= sub_off[RW-1:0];
         cnt_q  <= '0;
      end else if (byte_take) begin
         hold_q <= {hold_q[HW-9:0], byte_dat};
         cnt_q  <= cnt_q + BCW'(1);
         if (cnt_q == BCW'(NBYTES - 1)) begin
            ws_q <= WS_SKIP;
         end
      end
   end

   // ---------------- shadow and working banks ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_q <= IDENT;
      end else if (word_wen) begin
         shd_q[int'(wk) * CW +: CW] <= word_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= IDENT;
      end else if (commit) begin
         act_q <= shd_q;
      end
   end

   assign rd_coef = act_q[int'({rd_row, rd_col}) * CW +: CW];

   // ---------------- assertions ----------------
   // R5 R6
   skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !sub_stb && (ws_q == WS_SKIP)) |=> $stable(shd_q));

   // R9
   sub_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_stb |=> $stable(shd_q));

   // R7
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_q));

endmodule

// File: rtl/chanmix_mac.sv
`timescale 1ns/1ps
module chanmix_mac #(
   parameter int unsigned NCH      = 8,
   parameter int unsigned SW       = 24,
   parameter int unsigned CW       = 28,
   parameter int unsigned FRAC     = 23,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [NCH*SW-1:0]       smp_in,
   input  logic [CW-1:0]           coef,
   output logic [$clog2(NCH)-1:0]  rd_row,
   output logic [$clog2(NCH)-1:0]  rd_col,
   output logic                    busy,
   output logic                    done,
   output logic [NCH*SW-1:0]       res
);

   localparam int unsigned RW  = $clog2(NCH);
   localparam int unsigned IW  = 2 * RW;
   localparam int unsigned PW  = SW + CW;
   localparam int unsigned AW  = PW + RW;
   localparam int unsigned LAT = NCH * NCH;
   localparam int unsigned LW  = $clog2(LAT + 1);

   logic                      busy_q;
   logic                      done_q;
   logic [IW-1:0]             idx_q;
   logic [NCH*SW-1:0]         smp_q;
   logic [NCH*SW-1:0]         res_q;
   logic [(NCH-1)*SW-1:0]     part_q;
   logic signed [AW-1:0]      acc_q;
   logic signed [AW-1:0]      acc_base;
   logic signed [AW-1:0]      acc_nx;
   logic signed [AW-1:0]      acc_shr;
   logic signed [SW-1:0]      x_cur;
   logic signed [CW-1:0]      c_cur;
   logic signed [PW-1:0]      prod;
   logic [SW-1:0]             y_sat;
   logic                      last_col;
   logic                      last_row;
   logic [LW-1:0]             lat_q;

   // index walks rows (outputs) slowly and columns (inputs) fast
   assign rd_row   = idx_q[IW-1:RW];
   assign rd_col   = idx_q[RW-1:0];
   assign last_col = (rd_col == RW'(NCH - 1));
   assign last_row = (rd_row == RW'(NCH - 1));

   assign x_cur    = smp_q[int'(rd_col) * SW +: SW];
   assign c_cur    = coef;
   assign prod     = x_cur * c_cur;
   assign acc_base = (rd_col == '0) ? '0 : acc_q;
   assign acc_nx   = acc_base + AW'(prod);
   assign acc_shr  = acc_nx >>> FRAC;

   chanmix_sat #(
      .IW       (AW),
      .OW       (SW),
      .SATURATE (SATURATE)
   ) u_sat (
      .din  (acc_shr),
      .dout (y_sat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         smp_q  <= '0;
         acc_q  <= '0;
         part_q <= '0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            smp_q  <= smp_in;
         end else if (busy_q) begin
            idx_q <= idx_q + IW'(1);
            acc_q <= acc_nx;
            if (last_col) begin
               if (last_row) begin
                  res_q  <= {y_sat, part_q};
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  part_q[int'(rd_row) * SW +: SW] <= y_sat;
               end
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign res  = res_q;

   // independent cycle counter for the latency check
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q <= '1;
      end else if (start) begin
         lat_q <= '0;
      end else if (lat_q != '1) begin
         lat_q <= lat_q + LW'(1);
      end
   end

   // R8
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (lat_q == LW'(LAT)));

   // R8
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);

endmodule

// File: rtl/chanmix_matrix.sv
`timescale 1ns/1ps
module chanmix_matrix
   import chanmix_pkg::*;
#(
   parameter int unsigned NCH      = 8,
   parameter int unsigned SW       = 24,
   parameter int unsigned CW       = 28,
   parameter int unsigned WORDW    = 32,
   parameter int unsigned FRAC     = 23,
   parameter logic [7:0]  SUB_BASE = 8'h41,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_sub_stb,
   input  logic [7:0]           cfg_sub,
   input  logic                 cfg_byte_stb,
   input  logic [7:0]           cfg_byte,
   input  logic                 in_vld,
   output logic                 in_rdy,
   input  logic [NCH*SW-1:0]    in_frame,
   output logic                 out_vld,
   output logic [NCH*SW-1:0]    out_frame
);

   localparam int unsigned RW  = $clog2(NCH);
   localparam int unsigned BPW = WORDW / 8;

   // ---------------- elaboration checks ----------------
   if (!is_pow2(NCH) || NCH < 2) begin : g_bad_nch
      $error("chanmix_matrix: NCH must be a power of two, at least 2");
   end
   if (WORDW % 8 != 0 || !is_pow2(BPW) || BPW < 4) begin : g_bad_word
      $error("chanmix_matrix: WORDW must be a power-of-two byte count of at least 4 bytes");
   end
   if (CW > WORDW || CW < 17) begin : g_bad_cw
      $error("chanmix_matrix: CW must lie between 17 and WORDW");
   end
   if (FRAC >= CW) begin : g_bad_frac
      $error("chanmix_matrix: FRAC must be smaller than CW");
   end
   if (int'(SUB_BASE) + int'(NCH) > 256) begin : g_bad_base
      $error("chanmix_matrix: subaddress window exceeds 8 bits");
   end

   logic            accept;
   logic            busy;
   logic            done;
   logic [RW-1:0]   rd_row;
   logic [RW-1:0]   rd_col;
   logic [CW-1:0]   coef;

   assign in_rdy  = !busy;
   assign accept  = in_vld && in_rdy;
   assign out_vld = done;

   chanmix_coef_bank #(
      .NCH      (NCH),
      .CW       (CW),
      .WORDW    (WORDW),
      .FRAC     (FRAC),
      .SUB_BASE (SUB_BASE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sub_stb  (cfg_sub_stb),
      .sub_addr (cfg_sub),
      .byte_stb (cfg_byte_stb),
      .byte_dat (cfg_byte),
      .commit   (accept),
      .rd_row   (rd_row),
      .rd_col   (rd_col),
      .rd_coef  (coef)
   );

   chanmix_mac #(
      .NCH      (NCH),
      .SW       (SW),
      .CW       (CW),
      .FRAC     (FRAC),
      .SATURATE (SATURATE)
   ) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .smp_in (in_frame),
      .coef   (coef),
      .rd_row (rd_row),
      .rd_col (rd_col),
      .busy   (busy),
      .done   (done),
      .res    (out_frame)
   );

   // R8
   rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_rdy);

   // R8
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> $stable(out_frame));

   // R8
   rdy_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> in_rdy);

endmodule

// File: tb/sim_chanmix_matrix.sv
`timescale 1ns/1ps
module sim_chanmix_matrix;

   localparam int NCH = 8;
   localparam int SW  = 24;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               cfg_sub_stb;
   logic [7:0]         cfg_sub;
   logic               cfg_byte_stb;
   logic [7:0]         cfg_byte;
   logic               in_vld;
   logic               in_rdy;
   logic [NCH*SW-1:0]  in_frame;
   logic               out_vld;
   logic [NCH*SW-1:0]  out_frame;

   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   int          acc_cyc = 0;
   int          shd [8][8];
   int          act [8][8];
   int          smp [8];
   int          exp_q [8];
   logic [31:0] wbuf [8];
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   chanmix_matrix u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_sub_stb  (cfg_sub_stb),
      .cfg_sub      (cfg_sub),
      .cfg_byte_stb (cfg_byte_stb),
      .cfg_byte     (cfg_byte),
      .in_vld       (in_vld),
      .in_rdy       (in_rdy),
      .in_frame     (in_frame),
      .out_vld      (out_vld),
      .out_frame    (out_frame)
   );

   task automatic chk(input string req, input string what, input longint got, input longint exp_v);
      n_chk++;
      if (got != exp_v) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp_v);
      end
   endtask

   function automatic logic [31:0] rnd32();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   function automatic int rnd24();
      logic [31:0] r;
      r = rnd32();
      return int'($signed(r[31:8]));
   endfunction

   function automatic int w2c(input logic [31:0] w);
      return int'($signed(w[27:0]));
   endfunction

   function automatic int exp_ch(input int o);
      longint s;
      s = 0;
      for (int i = 0; i < NCH; i++) s += longint'(smp[i]) * longint'(act[o][i]);
      s = s >>> 23;
      if (s > 64'sd8388607) s = 64'sd8388607;
      else if (s < -64'sd8388608) s = -64'sd8388608;
      return int'(s);
   endfunction

   function automatic int out_ch(input int o);
      return int'($signed(out_frame[o*SW +: SW]));
   endfunction

   task automatic load_frame();
      for (int i = 0; i < NCH; i++) in_frame[i*SW +: SW] = smp[i][23:0];
   endtask

   task automatic rand_smp();
      for (int i = 0; i < NCH; i++) smp[i] = rnd24();
   endtask

   task automatic rand_words();
      for (int k = 0; k < NCH; k++) begin
         logic [31:0] r;
         int g;
         r = rnd32();
         g = rnd24() * 2;
         wbuf[k] = {r[3:0], 28'(g)};
      end
   endtask

   task automatic take_commit();
      for (int o = 0; o < NCH; o++)
         for (int i = 0; i < NCH; i++) act[o][i] = shd[o][i];
      for (int o = 0; o < NCH; o++) exp_q[o] = exp_ch(o);
      acc_cyc = cyc;
   endtask

   task automatic send_sub(input logic [7:0] s);
      cfg_sub_stb = 1'b1;
      cfg_sub     = s;
      @(negedge clk);
      cfg_sub_stb = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      cfg_byte_stb = 1'b1;
      cfg_byte     = b;
      @(negedge clk);
      cfg_byte_stb = 1'b0;
   endtask

   // R3: write nb bytes of wbuf to mixer n (subaddress 0x40+n), MSB first
   task automatic wr_mixer(input int n, input int nb, input bit with_sub);
      if (with_sub) send_sub(8'(8'h40 + n));
      for (int b = 0; b < nb; b++) begin
         logic [7:0] bv;
         if (b < 32) bv = wbuf[b/4][8*(3 - b%4) +: 8];
         else        bv = (b % 4 == 1) ? 8'h80 : 8'h00;
         send_byte(bv);
         if (n >= 1 && n <= 8 && b < 32 && b % 4 == 3) shd[n-1][b/4] = w2c(wbuf[b/4]);
      end
   endtask

   task automatic start_frame();
      load_frame();
      while (!in_rdy) @(negedge clk);
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      take_commit();
      chk("R8", "in_rdy after accept", longint'(in_rdy), 0);
   endtask

   task automatic finish_frame(input string req);
      logic [NCH*SW-1:0] held;
      while (!out_vld) @(negedge clk);
      chk("R8", "latency", longint'(cyc - acc_cyc), 64);
      chk("R8", "in_rdy at result", longint'(in_rdy), 1);
      for (int o = 0; o < NCH; o++) chk(req, $sformatf("out ch%0d", o), longint'(out_ch(o)), longint'(exp_q[o]));
      held = out_frame;
      @(negedge clk);
      chk("R8", "out_vld pulse width", longint'(out_vld), 0);
      chk("R8", "out_frame held", longint'(out_frame == held), 1);
   endtask

   task automatic frame(input string req);
      start_frame();
      finish_frame(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n        = 1'b0;
      cfg_sub_stb  = 1'b0;
      cfg_sub      = '0;
      cfg_byte_stb = 1'b0;
      cfg_byte     = '0;
      in_vld       = 1'b0;
      in_frame     = '0;
      for (int o = 0; o < NCH; o++)
         for (int i = 0; i < NCH; i++) shd[o][i] = (o == i) ? 32'h0080_0000 : 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk("R8", "reset in_rdy", longint'(in_rdy), 1);
      chk("R8", "reset out_vld", longint'(out_vld), 0);
      chk("R8", "reset out_frame zero", longint'(out_frame == '0), 1);

      // R4 identity pass-through
      for (int f = 0; f < 3; f++) begin
         rand_smp();
         frame("R4");
      end
      for (int i = 0; i < NCH; i++) smp[i] = (i % 2 == 0) ? 8388607 : -8388608;
      frame("R4");

      // R3 / R2 sweep: every mixer rewritten with random gains and junk top nibbles
      for (int n = 1; n <= NCH; n++) begin
         rand_words();
         wr_mixer(n, 32, 1'b1);
         for (int f = 0; f < 2; f++) begin
            rand_smp();
            frame("R3");
         end
      end
      // R1 general mixing
      for (int f = 0; f < 4; f++) begin
         rand_smp();
         frame("R1");
      end

      // R2 top nibble ignored, negative unity
      for (int k = 0; k < NCH; k++) wbuf[k] = 32'h0;
      wbuf[0] = 32'hF080_0000;
      wbuf[1] = 32'h0F80_0000;
      wr_mixer(1, 32, 1'b1);
      for (int i = 0; i < NCH; i++) smp[i] = rnd24() / 4;
      frame("R2");
      chk("R2", "ch0 equals x0-x1", longint'(out_ch(0)), longint'(smp[0] - smp[1]));

      // R10 saturation both ways
      for (int k = 0; k < NCH; k++) wbuf[k] = 32'h07FF_FFFF;
      wr_mixer(2, 32, 1'b1);
      for (int i = 0; i < NCH; i++) smp[i] = 8388607;
      frame("R10");
      chk("R10", "ch1 positive clip", longint'(out_ch(1)), 8388607);
      for (int i = 0; i < NCH; i++) smp[i] = -8388608;
      frame("R10");
      chk("R10", "ch1 negative clip", longint'(out_ch(1)), -8388608);

      // R5 partial trailing word, then overlong write
      rand_words();
      wr_mixer(3, 14, 1'b1);
      rand_smp();
      frame("R5");
      rand_words();
      wr_mixer(4, 40, 1'b1);
      rand_smp();
      frame("R5");

      // R6 subaddresses outside the window
      for (int k = 0; k < NCH; k++) wbuf[k] = 32'h0080_0000;
      wr_mixer(0, 32, 1'b1);
      wr_mixer(9, 32, 1'b1);
      wr_mixer(8'h81, 32, 1'b1);
      rand_smp();
      frame("R6");

      // R9 subaddress and byte in the same cycle
      rand_words();
      send_sub(8'h45);
      send_byte(8'h12);
      send_byte(8'h34);
      cfg_sub_stb  = 1'b1;
      cfg_sub      = 8'h46;
      cfg_byte_stb = 1'b1;
      cfg_byte     = 8'h7F;
      @(negedge clk);
      cfg_sub_stb  = 1'b0;
      cfg_byte_stb = 1'b0;
      wr_mixer(6, 32, 1'b0);
      rand_smp();
      frame("R9");

      // R7 write while a frame is in progress
      rand_words();
      rand_smp();
      start_frame();
      wr_mixer(7, 32, 1'b1);
      finish_frame("R7");
      rand_smp();
      frame("R7");

      // R7 word completes on the accepting edge
      rand_words();
      wbuf[0] = 32'h0040_0000;
      send_sub(8'h48);
      send_byte(wbuf[0][31:24]);
      send_byte(wbuf[0][23:16]);
      send_byte(wbuf[0][15:8]);
      rand_smp();
      load_frame();
      in_vld       = 1'b1;
      cfg_byte_stb = 1'b1;
      cfg_byte     = wbuf[0][7:0];
      @(negedge clk);
      in_vld       = 1'b0;
      cfg_byte_stb = 1'b0;
      take_commit();
      shd[7][0] = w2c(wbuf[0]);
      chk("R7", "in_rdy after concurrent accept", longint'(in_rdy), 0);
      finish_frame("R7");
      frame("R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule